// File: doc/BRIEF.md
# SPI Serial Flash Read Front End

This block is the slave-side serial engine of a small SPI NOR flash model. It watches chip select, serial clock, serial input and the hold pin, all sampled on the system clock. From these it collects an 8-bit opcode, a 24-bit address and, for the fast commands, one dummy byte. It then streams data back most significant bit first. The data comes either from the on-chip array, through a plain byte read port, or from a built-in identification sequence. The output pins are modelled as a data bit plus an output enable, one pair for the primary output and one for the shared data line that is used in dual mode.

SCK idle low (mode 0) and SCK idle high (mode 3) are both handled. Input is captured on rising SCK edges and output changes on falling SCK edges. The array read port carries no handshake, because SCK cannot be stalled. The address leaves the block and the memory must return the byte at that address combinationally, in the same system clock cycle. The data streams are therefore not valid/ready interfaces and have no back-pressure: the SPI master sets the pace by clocking SCK. SCK must stay at or below one quarter of the system clock rate, and every input must be synchronous to the system clock.

Top module: `spi_flash_fe`

## Requirements
- R1: While cs_n is high, and after reset, so_oe and sio_oe are 0. Raising cs_n ends any command, and the next low period starts with a fresh opcode.
- R2: Opcode 03h is followed by a 24-bit address, MSB first. Data starts at the first falling SCK edge after the last address bit, and each byte is sent on so MSB first.
- R3: Opcode 0Bh inserts 8 dummy SCK clocks between the address and the first data bit. Otherwise it behaves like 03h.
- R4: Opcode 3Bh uses the 0Bh framing. Each data clock then drives bit 7-2k on so and bit 6-2k on sio, so a byte takes 4 clocks. sio_oe is 1 only in this data phase.
- R5: Only the low ADDR_W address bits are decoded and the upper bits are ignored. The read address goes up by one after every byte and wraps from 2^ADDR_W-1 to 0.
- R6: Opcode 9Fh returns 7Fh, 9Dh, DEV_ID, repeating while SCK runs and cs_n stays low.
- R7: Opcode 90h takes a 24-bit address. If address bit 0 is 0, it loops 9Dh, DEV_ID, 7Fh. If bit 0 is 1, it loops DEV_ID, 9Dh, 7Fh.
- R8: hold_n low while SCK is low pauses the transfer: both enables drop and SCK edges and input are ignored. hold_n high while SCK is low resumes the transfer at the same bit.
- R9: An unknown opcode makes the block ignore all input and drive nothing until cs_n rises. Input seen during a data phase is ignored.
- R10: Every command works the same way with SCK idling high (mode 3) as with SCK idling low (mode 0).
- R11: While enabled, so changes only after a falling SCK edge, and so_oe rises only while SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled on clk |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low |
| mem_rdata | input | 8 | Array byte at mem_addr, same cycle |
| mem_addr | output | ADDR_W | Array byte address |
| so | output | 1 | Primary serial output data |
| so_oe | output | 1 | Output enable for so |
| sio | output | 1 | Second output bit in dual mode |
| sio_oe | output | 1 | Output enable for sio |

## Verification
The checker covers rules that must hold on every cycle. Both enables stay off while the device is deselected. A hold taken with SCK low blanks the outputs on the next cycle. The so bit moves only after a falling SCK edge, and the output enable only rises while SCK is low. The byte values themselves can only be shown by the bench's scenarios: address framing and dummy length, dual bit pairing, wrap at the top of the array, the two ID orders and their looping, resumption after a hold at the right bit, and the discard of an unknown opcode.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_t;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_JEDEC, SRC_MFDEV} src_t;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_MFDEV = 8'h90;
  localparam logic [7:0] ID_MFR   = 8'h9D;
  localparam logic [7:0] ID_BANK  = 8'h7F;
  localparam int unsigned ADDR_FIELD = 24;
endpackage

// File: rtl/spi_fe_pins.sv
module spi_fe_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic held
);
  logic sck_q;
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n)
        held <= 1'b0;
      else if (!sck)
        held <= !hold_n;
    end
  end

  assign active = !cs_n && !held;
  assign rise   = active && sck && !sck_q;
  assign fall   = active && !sck && sck_q;
endmodule

// File: rtl/spi_fe_idgen.sv
module spi_fe_idgen
  import spi_fe_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h13
) (
  input  src_t       src,
  input  logic       a0,
  input  logic [1:0] idx,
  output logic [7:0] id_byte
);
  always_comb begin
    id_byte = ID_BANK;
    if (src == SRC_JEDEC) begin
      case (idx)
        2'd0:    id_byte = ID_BANK;
        2'd1:    id_byte = ID_MFR;
        default: id_byte = DEV_ID;
      endcase
    end else begin
      case (idx)
        2'd0:    id_byte = a0 ? DEV_ID : ID_MFR;
        2'd1:    id_byte = a0 ? ID_MFR : DEV_ID;
        default: id_byte = ID_BANK;
      endcase
    end
  end
endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
  import spi_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              si,
  input  logic [7:0]        cur,
  output src_t              src,
  output logic              dual,
  output logic              a0,
  output logic [1:0]        idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              so_r,
  output logic              sio_r,
  output logic              drv
);
  localparam int unsigned CNT_W = $clog2(ADDR_FIELD);

  phase_t                  phase;
  logic [6:0]              shreg;
  logic [CNT_W-1:0]        cnt;
  logic [7:0]              op;
  logic [ADDR_FIELD-1:0]   addr;
  logic [2:0]              obit;
  logic [7:0]              cmd_byte;
  logic                    last_bit;

  assign cmd_byte = {shreg, si};
  assign dual     = (op == OP_DUAL);
  assign src      = (op == OP_JEDEC) ? SRC_JEDEC : (op == OP_MFDEV) ? SRC_MFDEV : SRC_ARRAY;
  assign a0       = addr[0];
  assign rd_addr  = addr[ADDR_W-1:0];
  assign last_bit = dual ? (obit == 3'd6) : (obit == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      shreg <= '0;
      cnt   <= '0;
      op    <= '0;
      addr  <= '0;
      obit  <= '0;
      idx   <= '0;
      so_r  <= 1'b0;
      sio_r <= 1'b0;
      drv   <= 1'b0;
    end else if (cs_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      obit  <= '0;
      idx   <= '0;
      so_r  <= 1'b0;
      sio_r <= 1'b0;
      drv   <= 1'b0;
    end else if (rise) begin
      unique case (phase)
        PH_CMD: begin
          shreg <= cmd_byte[6:0];
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            op  <= cmd_byte;
            case (cmd_byte)
              OP_READ, OP_FAST, OP_DUAL, OP_MFDEV: phase <= PH_ADDR;
              OP_JEDEC:                            phase <= PH_DATA;
              default:                             phase <= PH_SKIP;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ADDR: begin
          addr <= {addr[ADDR_FIELD-2:0], si};
          if (cnt == CNT_W'(ADDR_FIELD - 1)) begin
            cnt   <= '0;
            phase <= (op == OP_READ || op == OP_MFDEV) ? PH_DATA : PH_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt == CNT_W'(7)) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (fall && phase == PH_DATA) begin
      drv   <= 1'b1;
      so_r  <= cur[3'd7 - obit];
      sio_r <= dual ? cur[3'd6 - obit] : 1'b0;
      obit  <= obit + (dual ? 3'd2 : 3'd1);
      if (last_bit) begin
        if (src == SRC_ARRAY)
          addr <= addr + 1'b1;
        idx <= (idx == 2'd2) ? 2'd0 : idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_fe.sv
module spi_flash_fe
  import spi_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter logic [7:0]  DEV_ID = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              so,
  output logic              so_oe,
  output logic              sio,
  output logic              sio_oe
);
  logic       rise, fall, held;
  src_t       src;
  logic       dual, a0, drv, so_r, sio_r;
  logic [1:0] idx;
  logic [7:0] id_byte, cur;

  spi_fe_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .rise(rise), .fall(fall), .held(held)
  );

  spi_fe_idgen #(.DEV_ID(DEV_ID)) u_id (
    .src(src), .a0(a0), .idx(idx), .id_byte(id_byte)
  );

  spi_fe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall), .si(si),
    .cur(cur), .src(src), .dual(dual), .a0(a0), .idx(idx), .rd_addr(mem_addr),
    .so_r(so_r), .sio_r(sio_r), .drv(drv)
  );

  assign cur    = (src == SRC_ARRAY) ? mem_rdata : id_byte;
  assign so     = so_r;
  assign sio    = sio_r;
  assign so_oe  = drv && !cs_n && !held;
  assign sio_oe = so_oe && dual;
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so,
  input logic so_oe,
  input logic sio_oe
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cyc <= 2'd0;
    else if (cyc != 2'd3)
      cyc <= cyc + 2'd1;
  end

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!so_oe && !sio_oe));

  a_r8_hold_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !hold_n && !sck) |=> (!so_oe && !sio_oe));

  a_r11_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && so_oe && $past(so_oe) && !($past(sck, 2) && !$past(sck))) |-> $stable(so));

  a_r11_oe_rises_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $rose(so_oe)) |-> !$past(sck));
endmodule

bind spi_flash_fe spi_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so(so), .so_oe(so_oe), .sio_oe(sio_oe)
);

// File: tb/sim_spi_flash_fe.sv
module sim_spi_flash_fe;
  localparam int unsigned AW = 19;
  localparam logic [7:0] DEV = 8'h13;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        m3;
    logic [3:0]  n;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h03, 24'h012345, 1'b0, 4'd3},
    '{8'h0B, 24'hF7FFFE, 1'b0, 4'd4},
    '{8'h3B, 24'h000100, 1'b0, 4'd3},
    '{8'h3B, 24'h07FFFF, 1'b1, 4'd2},
    '{8'h9F, 24'h000000, 1'b0, 4'd7},
    '{8'h90, 24'h000000, 1'b0, 4'd6},
    '{8'h90, 24'h000001, 1'b1, 4'd6},
    '{8'h03, 24'h07FFFF, 1'b1, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic so, so_oe, sio, sio_oe;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA6;
  endfunction

  assign mem_rdata = fmem(mem_addr);

  spi_flash_fe u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .so(so), .so_oe(so_oe), .sio(sio), .sio_oe(sio_oe)
  );

  function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic [23:0] a, input int i);
    int k;
    k = i % 3;
    case (op)
      8'h9F: return (k == 0) ? 8'h7F : (k == 1) ? 8'h9D : DEV;
      8'h90: begin
        if (!a[0]) return (k == 0) ? 8'h9D : (k == 1) ? DEV : 8'h7F;
        else       return (k == 0) ? DEV : (k == 1) ? 8'h9D : 8'h7F;
      end
      default: return fmem(a[AW-1:0] + AW'(i));
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic o, output logic o2, output logic oe, output logic oe2);
    @(negedge clk); sck = 1'b0; si = b;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    o = so; o2 = sio; oe = so_oe; oe2 = sio_oe;
    repeat (2) @(negedge clk);
  endtask

  task automatic begin_cmd(input logic m3);
    @(negedge clk); sck = m3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_cmd(input logic m3);
    @(negedge clk); sck = m3;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic any_oe);
    logic o, o2, oe, oe2;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xfer(b[i], o, o2, oe, oe2);
      any_oe |= oe | oe2;
    end
  endtask

  task automatic read_byte(input logic dual, output logic [7:0] b, output logic oe_ok);
    logic o, o2, oe, oe2;
    oe_ok = 1'b1;
    if (dual) begin
      for (int k = 0; k < 4; k++) begin
        xfer(k[0], o, o2, oe, oe2);
        b[7 - 2*k] = o; b[6 - 2*k] = o2;
        oe_ok &= oe & oe2;
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        xfer(~k[0], o, o2, oe, oe2);
        b[7 - k] = o;
        oe_ok &= oe & !oe2;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic ok, any;
    logic o, o2, oe, oe2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset so_oe", {7'b0, so_oe}, 8'h00);
    chk("R1 reset sio_oe", {7'b0, sio_oe}, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < 8; v++) begin
      logic dual;
      dual = (VEC[v].op == 8'h3B);
      begin_cmd(VEC[v].m3);
      send_byte(VEC[v].op, any);
      if (VEC[v].op != 8'h9F) begin
        for (int j = 2; j >= 0; j--) send_byte(VEC[v].addr[8*j +: 8], any);
      end
      if (VEC[v].op == 8'h0B || VEC[v].op == 8'h3B) begin
        send_byte(8'hFF, any);
        chk("R3 no output before data", {7'b0, any}, 8'h00);
      end
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        read_byte(dual, b, ok);
        chk($sformatf("R2/R4/R5/R6/R7/R10 vec %0d byte %0d", v, i), b, exp_byte(VEC[v].op, VEC[v].addr, i));
        chk($sformatf("R4 enables vec %0d byte %0d", v, i), {7'b0, ok}, 8'h01);
      end
      end_cmd(VEC[v].m3);
      chk("R1 released after cs_n high", {6'b0, so_oe, sio_oe}, 8'h00);
    end

    // R9: unknown opcode discards everything until cs_n rises
    begin_cmd(1'b0);
    send_byte(8'hA5, any);
    send_byte(8'h03, any);
    send_byte(8'h00, any);
    send_byte(8'h00, any);
    send_byte(8'h10, any);
    send_byte(8'h00, any);
    chk("R9 unknown opcode drives nothing", {7'b0, any}, 8'h00);
    end_cmd(1'b0);
    begin_cmd(1'b0);
    send_byte(8'h9F, any);
    read_byte(1'b0, b, ok);
    chk("R9 next command after cs_n", b, 8'h7F);
    end_cmd(1'b0);

    // R8: hold in the middle of a byte
    begin_cmd(1'b0);
    send_byte(8'h03, any);
    send_byte(8'h00, any);
    send_byte(8'h00, any);
    send_byte(8'h40, any);
    for (int k = 0; k < 3; k++) begin
      xfer(1'b1, o, o2, oe, oe2);
      b[7 - k] = o;
    end
    @(negedge clk); sck = 1'b0;
    repeat (4) @(negedge clk);
    hold_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 outputs released in hold", {6'b0, so_oe, sio_oe}, 8'h00);
    for (int t = 0; t < 2; t++) begin
      sck = 1'b1; si = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; si = 1'b0; repeat (4) @(negedge clk);
    end
    chk("R8 still released after clocks", {7'b0, so_oe}, 8'h00);
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    b[4] = so;
    chk("R8 enable back after resume", {7'b0, so_oe}, 8'h01);
    repeat (2) @(negedge clk);
    for (int k = 4; k < 8; k++) begin
      xfer(1'b0, o, o2, oe, oe2);
      b[7 - k] = o;
    end
    chk("R8 byte intact across hold", b, fmem(19'h00040));
    read_byte(1'b0, b, ok);
    chk("R8 next byte after hold", b, fmem(19'h00041));
    end_cmd(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule